// File: doc/BRIEF.md
# Boundary-Scan Bidirectional Pin Segment

This block is one segment of a boundary-scan data register. It serves a group of bidirectional pins whose drivers share one direction flop. The segment holds one direction cell and N bidirectional cells. Each cell has a shift flop and an update flop. The shift flops form a serial path from `scan_i` to `scan_o`.

In functional mode the segment is transparent. Device data goes to the pins, pin values go to the device, and the device output enable drives the pin tri-state control. In test mode the update flops take over the pins and the device inputs. The direction update flop decides two things: whether each bidirectional cell samples device data or pin data on capture, and whether the pins are driven. During internal test the pins are held in high impedance. The scanned direction still selects the capture source.

Decoded TAP strobes come in as single-cycle enables on the test clock. The TAP controller and the instruction decode sit outside this block.

Top module: `bscan_bidir_seg`

## Requirements
- R1: While `rst_ni` is low, every shift flop and every update flop is 0. With `mode_i`=1 this gives `pin_out_o`=0, `dev_di_o`=0, `pin_oe_o`=0 and `scan_o`=0.
- R2: With `mode_i`=0, `pin_out_o` equals `dev_do_i` and `dev_di_o` equals `pin_in_i`. With `mode_i`=0 and `intest_i`=0, `pin_oe_o` equals `dev_oe_i`. All three paths are combinational.
- R3: With `mode_i`=1, bit k of `pin_out_o` and bit k of `dev_di_o` both equal the update flop of bidirectional cell k.
- R4: On a clock edge with `capture_i`=1, the direction shift flop loads `dev_oe_i`. Each bidirectional shift flop loads bit k of `dev_do_i` when the direction value is 1, and bit k of `pin_in_i` when it is 0. The direction value is `dev_oe_i` when `mode_i`=0 and the direction update flop when `mode_i`=1. `capture_i` takes priority over `shift_i`.
- R5: On a clock edge with `shift_i`=1 and `capture_i`=0, data moves one stage toward the scan output. The order is `scan_i`, then the direction flop, then cells 0 to N-1. `scan_o` is the shift flop of cell N-1.
- R6: On a clock edge with `update_i`=1, every update flop loads the value its shift flop held before that edge. Bidirectional update flops hold at all other times, including while shifting or capturing.
- R7: On a clock edge with `tlr_i`=1, the direction update flop clears to 0, and this overrides `update_i`. The bidirectional update flops are not affected by `tlr_i`.
- R8: While `intest_i`=1, `pin_oe_o` is 0 whatever the direction value is.
- R9: With `mode_i`=1 and `intest_i`=0, `pin_oe_o` equals the direction update flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tlr_i | input | 1 | Test-logic-reset state indication |
| mode_i | input | 1 | 1 = pins under test control |
| intest_i | input | 1 | Internal test active; pins floated |
| scan_i | input | 1 | Serial input |
| dev_do_i | input | N_CELLS | Device output data |
| dev_oe_i | input | 1 | Device output enable for the group |
| pin_in_i | input | N_CELLS | Values received from the pins |
| pin_out_o | output | N_CELLS | Values driven to the pins |
| pin_oe_o | output | 1 | Pin tri-state enable for the group |
| dev_di_o | output | N_CELLS | Values delivered to device inputs |
| scan_o | output | 1 | Serial output |

## Verification
A wrong shift or capture flop stays hidden until it reaches the serial output. At worst that takes N+1 shift cycles. A wrong update flop shows up at once on `pin_out_o` and `dev_di_o` in test mode. A bad direction update flop shows on `pin_oe_o` in the same cycle. It also corrupts the next capture of every bidirectional cell, and that corruption reaches `scan_o` one shift sequence later. The bench compares all outputs against a behavioural queue model on every cycle, so each error is caught at the first cycle where it becomes visible.

// File: rtl/bscan_seg_pkg.sv
package bscan_seg_pkg;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } dr_ctl_t;

  // capture wins over shift; otherwise hold
  function automatic logic next_shift(dr_ctl_t c, logic cap_v, logic ser_v, logic cur);
    if (c.capture)    return cap_v;
    else if (c.shift) return ser_v;
    else              return cur;
  endfunction

endpackage

// File: rtl/bscan_dir_cell.sv
module bscan_dir_cell
  import bscan_seg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  dr_ctl_t ctl_i,
  input  logic    tlr_i,
  input  logic    dev_oe_i,
  input  logic    ser_i,
  output logic    sh_o,
  output logic    upd_o
);

  logic sh_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 1'b0;
    else         sh_q <= next_shift(ctl_i, dev_oe_i, ser_i, sh_q);
  end

  // tlr clear beats update: no pin drives on first EXTEST entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           upd_q <= 1'b0;
    else if (tlr_i)        upd_q <= 1'b0;
    else if (ctl_i.update) upd_q <= sh_q;
  end

  assign sh_o  = sh_q;
  assign upd_o = upd_q;

  p_tlr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlr_i |=> !upd_o);

  p_dir_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tlr_i && !ctl_i.update) |=> $stable(upd_o));

  p_dir_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.capture |=> sh_o == $past(dev_oe_i));

endmodule

// File: rtl/bscan_bidir_cell.sv
module bscan_bidir_cell
  import bscan_seg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  dr_ctl_t ctl_i,
  input  logic    mode_i,
  input  logic    holi_i,
  input  logic    dev_do_i,
  input  logic    pin_in_i,
  input  logic    ser_i,
  output logic    sh_o,
  output logic    pin_out_o,
  output logic    dev_di_o
);

  logic sh_q, upd_q, cap_v;

  // direction reconfigures the cell as output or input cell
  assign cap_v = holi_i ? dev_do_i : pin_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 1'b0;
    else         sh_q <= next_shift(ctl_i, cap_v, ser_i, sh_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           upd_q <= 1'b0;
    else if (ctl_i.update) upd_q <= sh_q;
  end

  assign sh_o      = sh_q;
  assign pin_out_o = mode_i ? upd_q : dev_do_i;
  assign dev_di_o  = mode_i ? upd_q : pin_in_i;

  p_upd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.update |=> $stable(upd_q));

  p_upd_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.update |=> upd_q == $past(sh_o));

  p_cap_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.capture |=> sh_o == ($past(holi_i) ? $past(dev_do_i) : $past(pin_in_i)));

endmodule

// File: rtl/bscan_bidir_seg.sv
module bscan_bidir_seg
  import bscan_seg_pkg::*;
#(
  parameter int N_CELLS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tlr_i,
  input  logic               mode_i,
  input  logic               intest_i,
  input  logic               scan_i,
  input  logic [N_CELLS-1:0] dev_do_i,
  input  logic               dev_oe_i,
  input  logic [N_CELLS-1:0] pin_in_i,
  output logic [N_CELLS-1:0] pin_out_o,
  output logic               pin_oe_o,
  output logic [N_CELLS-1:0] dev_di_o,
  output logic               scan_o
);

  localparam int CHAIN_LEN = N_CELLS + 1;

  dr_ctl_t ctl;
  logic [CHAIN_LEN-1:0] chain;
  logic dir_upd, holi;

  assign ctl = '{capture: capture_i, shift: shift_i, update: update_i};

  bscan_dir_cell u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .tlr_i    (tlr_i),
    .dev_oe_i (dev_oe_i),
    .ser_i    (scan_i),
    .sh_o     (chain[0]),
    .upd_o    (dir_upd)
  );

  assign holi = mode_i ? dir_upd : dev_oe_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    bscan_bidir_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_i     (ctl),
      .mode_i    (mode_i),
      .holi_i    (holi),
      .dev_do_i  (dev_do_i[k]),
      .pin_in_i  (pin_in_i[k]),
      .ser_i     (chain[k]),
      .sh_o      (chain[k+1]),
      .pin_out_o (pin_out_o[k]),
      .dev_di_o  (dev_di_o[k])
    );

    p_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !capture_i) |=> chain[k+1] == $past(chain[k]));
  end

  // buffer floated during internal test
  assign pin_oe_o = holi & ~intest_i;
  assign scan_o   = chain[CHAIN_LEN-1];

  p_scan_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> chain[0] == $past(scan_i));

  p_intest_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intest_i |-> !pin_oe_o);

  initial begin
    p_min_cells: assert (N_CELLS >= 1);
  end

endmodule

// File: tb/bscan_bidir_seg_bench.sv
`timescale 1ns/1ps
module bscan_bidir_seg_bench;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture = 0, shift = 0, update = 0, tlr = 0, mode = 0, intest = 0, sin = 0;
  logic [N-1:0] dev_do = '0, pin_in = '0;
  logic dev_oe = 0;
  logic [N-1:0] pin_out, dev_di;
  logic pin_oe, sout;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  bscan_bidir_seg #(.N_CELLS(N)) u_bscan_bidir_seg (
    .clk_i(clk), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .tlr_i(tlr), .mode_i(mode), .intest_i(intest),
    .scan_i(sin), .dev_do_i(dev_do), .dev_oe_i(dev_oe), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .dev_di_o(dev_di), .scan_o(sout)
  );

  // reference model: queue index 0 = direction stage, i+1 = cell i
  bit q[$];
  bit m_dir_up;
  bit m_up[N];

  initial begin
    for (int i = 0; i <= N; i++) q.push_back(1'b0);
    m_dir_up = 0;
    for (int i = 0; i < N; i++) m_up[i] = 0;
  end

  function automatic bit m_holi();
    return mode ? m_dir_up : dev_oe;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= N; i++) q[i] = 0;
      m_dir_up = 0;
      for (int i = 0; i < N; i++) m_up[i] = 0;
    end else begin
      bit old[$];
      bit h;
      old = q;
      h = m_holi();
      if (capture) begin
        q[0] = dev_oe;
        for (int i = 0; i < N; i++) q[i+1] = h ? dev_do[i] : pin_in[i];
      end else if (shift) begin
        q.push_front(sin);
        void'(q.pop_back());
      end
      if (update) for (int i = 0; i < N; i++) m_up[i] = old[i+1];
      if (tlr) m_dir_up = 0;
      else if (update) m_dir_up = old[0];
    end
  end

  task automatic chk(string sub, string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s %s act=%b exp=%b t=%0t", tag, req, sub, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [N-1:0] e_out, e_di;
    for (int i = 0; i < N; i++) begin
      e_out[i] = mode ? m_up[i] : dev_do[i];
      e_di[i]  = mode ? m_up[i] : pin_in[i];
    end
    chk("pin_out_o", mode ? "R3" : "R2", pin_out, e_out);
    chk("dev_di_o",  mode ? "R3" : "R2", dev_di, e_di);
    chk("pin_oe_o",  intest ? "R8" : (mode ? "R9" : "R2"),
        {{(N-1){1'b0}}, pin_oe}, {{(N-1){1'b0}}, (intest ? 1'b0 : m_holi())});
    chk("scan_o", "R5", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, q[N]});
  endtask

  task automatic cyc(logic c, logic s, logic u, logic t, logic si);
    capture = c; shift = s; update = u; tlr = t; sin = si;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic shift_in(logic [N:0] bits);
    for (int i = 0; i <= N; i++) cyc(0, 1, 0, 0, bits[i]);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1";
    mode = 1;
    repeat (3) @(negedge clk);
    check_all();
    chk("reset pin_out_o", "R1", pin_out, '0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0);

    // R2 functional transparency
    tag = "R2";
    mode = 0;
    for (int i = 0; i < 6; i++) begin
      dev_do = N'($urandom); pin_in = N'($urandom); dev_oe = 1'($urandom);
      cyc(0, 0, 0, 0, 0);
    end

    // R5 shift order
    tag = "R5";
    shift_in({1'b1, {(N-1){1'b0}}, 1'b1});
    shift_in('0);

    // R4 capture: device data with enable 1, pin data with enable 0
    tag = "R4";
    dev_do = 4'b1010; pin_in = 4'b0110; dev_oe = 1;
    cyc(1, 0, 0, 0, 0);
    shift_in('0);
    dev_oe = 0;
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0); // capture over shift
    shift_in('0);

    // R6 update load and hold while shifting
    tag = "R6";
    shift_in({4'b1101, 1'b1});
    cyc(0, 0, 1, 0, 0);
    mode = 1;
    cyc(0, 0, 0, 0, 0);
    shift_in({4'b0010, 1'b0});
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);

    // R9 scanned direction drives enable and capture source
    tag = "R9";
    shift_in({4'b1111, 1'b1});
    cyc(0, 0, 1, 0, 0);
    dev_do = 4'b0101; pin_in = 4'b1010;
    cyc(1, 0, 0, 0, 0);
    shift_in('0);

    // R7 tlr clears direction only; tlr beats update
    tag = "R7";
    shift_in({4'b1010, 1'b1});
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    // R8 internal test floats pins but direction still picks capture source
    tag = "R8";
    shift_in({4'b0000, 1'b1});
    cyc(0, 0, 1, 0, 0);
    intest = 1;
    dev_do = 4'b1001; pin_in = 4'b0110;
    cyc(1, 0, 0, 0, 0);
    shift_in('0);
    intest = 0;

    // mixed random traffic
    tag = "RND";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      mode = 1'($urandom); intest = ($urandom_range(0, 7) == 0);
      dev_do = N'($urandom); pin_in = N'($urandom); dev_oe = 1'($urandom);
      cyc(sel == 0, sel >= 1 && sel <= 6, sel == 7, sel == 8, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule